// File: doc/BRIEF.md
# Multi-Bit Signal Change Detector

The block samples a word of input signals once per scan, on a one-cycle scan strobe. It keeps the word it saw on the previous strobe. On every strobe it reports three masks against that stored word: the bit positions that changed, the positions that went from 0 to 1, and the positions that went from 1 to 0. A keep mask removes positions that the caller does not care about, and those positions read as 0 in all three masks. The block also drives a rising pulse and a falling pulse for one chosen bit position. Each pulse lasts for exactly one scan.

All results are registered on the strobe and hold until the next strobe, so a scan-driven controller can read them at any point within the scan. The first strobe after reset only loads the stored word and reports no edges. It has no earlier sample to compare against.

Top module: `sigchg_det`

## Requirements
- R1: While reset is held and after it is released, before any strobe, every mask output and both pulse outputs are 0.
- R2: The first strobe after reset reports all-zero masks and zero pulses, and it stores the sampled word as the previous word.
- R3: On each later strobe the changed mask becomes (previous word XOR current word) AND keep mask. The previous word is then replaced by the current word.
- R4: The rising mask equals the changed mask AND the current word, which marks the 0-to-1 transitions.
- R5: The falling mask equals the changed mask AND the previous word, which marks the 1-to-0 transitions.
- R6: Between strobes all outputs hold their values, whatever the word, keep mask and select inputs do.
- R7: A position that is 0 in the keep mask reads 0 in all three masks. The stored previous word still takes the full, unmasked input. So a bit that toggles while it is masked and then stays put reports no change once it is kept again.
- R8: The selected-rise and selected-fall outputs equal bit number sel_i (sampled at the strobe) of the rising and falling masks. Each stays high for one scan only, unless the next scan repeats the edge.
- R9: With previous low nibble 1010 and current low nibble 1100, all bits kept, the low nibbles read changed 0110, rising 0100 and falling 0010.
- R10: The results of a strobe appear on the outputs in the clock cycle that follows the edge at which the strobe was sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_i | input | 1 | Scan strobe; one cycle high per scan |
| word_i | input | W (16) | Input signal word |
| keep_mask_i | input | W (16) | 1 = position is reported, 0 = forced to 0 |
| sel_i | input | SELW (4) | Bit position that drives the single-bit pulses |
| chg_o | output | W (16) | Changed mask |
| rise_o | output | W (16) | 0-to-1 mask |
| fall_o | output | W (16) | 1-to-0 mask |
| sel_rise_o | output | 1 | Rising pulse of the selected bit |
| sel_fall_o | output | 1 | Falling pulse of the selected bit |

## Verification
Every result of a strobe sits one register from the inputs. The bench raises the strobe on a falling edge and drops it on the next falling edge. It then compares all five outputs at that point, half a cycle after the capturing edge. It then changes every input with no strobe for one cycle and expects the outputs unchanged, which tests the hold between scans. The bench sweeps every pair of old and new low nibbles with several keep masks and select values, and computes the expected masks bit by bit from its own model of the previous word.

// File: rtl/sigchg_pkg.sv
`timescale 1ns/1ps
package sigchg_pkg;

  typedef struct packed {
    logic fall;
    logic rise;
    logic chg;
  } edge_t;

  // Edge of one bit position between two samples, gated by its keep bit.
  function automatic edge_t bit_edge(input logic old_b, input logic new_b,
                                     input logic keep_b);
    edge_t e;
    e.chg  = (old_b ^ new_b) & keep_b;
    e.rise = e.chg & new_b;
    e.fall = e.chg & old_b;
    return e;
  endfunction

endpackage

// File: rtl/sigchg_prev.sv
`timescale 1ns/1ps
module sigchg_prev #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] prev_o,
  output logic         primed_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_o   <= '0;
      primed_o <= 1'b0;
    end else if (load_i) begin
      prev_o   <= word_i;
      primed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sigchg_calc.sv
`timescale 1ns/1ps
module sigchg_calc
  import sigchg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] keep_i,
  input  logic         valid_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    edge_t e;
    always_comb begin
      e = bit_edge(prev_i[b], word_i[b], keep_i[b]);
      chg_o[b]  = e.chg  & valid_i;
      rise_o[b] = e.rise & valid_i;
      fall_o[b] = e.fall & valid_i;
    end
  end
endmodule

// File: rtl/sigchg_pick.sv
`timescale 1ns/1ps
module sigchg_pick #(
  parameter int W    = 16,
  parameter int SELW = 4
) (
  input  logic [W-1:0]    rise_i,
  input  logic [W-1:0]    fall_i,
  input  logic [SELW-1:0] sel_i,
  output logic            rise_o,
  output logic            fall_o
);
  always_comb begin
    rise_o = 1'b0;
    fall_o = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (sel_i == SELW'(b)) begin
        rise_o = rise_i[b];
        fall_o = fall_i[b];
      end
    end
  end
endmodule

// File: rtl/sigchg_out.sv
`timescale 1ns/1ps
module sigchg_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] chg_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic         srise_i,
  input  logic         sfall_i,
  output logic [W-1:0] chg_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic         srise_o,
  output logic         sfall_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_o   <= '0;
      rise_o  <= '0;
      fall_o  <= '0;
      srise_o <= 1'b0;
      sfall_o <= 1'b0;
    end else if (load_i) begin
      chg_o   <= chg_i;
      rise_o  <= rise_i;
      fall_o  <= fall_i;
      srise_o <= srise_i;
      sfall_o <= sfall_i;
    end
  end
endmodule

// File: rtl/sigchg_det.sv
`timescale 1ns/1ps
module sigchg_det #(
  parameter int W    = 16,
  parameter int SELW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_i,
  input  logic [W-1:0]    word_i,
  input  logic [W-1:0]    keep_mask_i,
  input  logic [SELW-1:0] sel_i,
  output logic [W-1:0]    chg_o,
  output logic [W-1:0]    rise_o,
  output logic [W-1:0]    fall_o,
  output logic            sel_rise_o,
  output logic            sel_fall_o
);
  logic [W-1:0] prev_w;
  logic         primed_w;
  logic [W-1:0] chg_n, rise_n, fall_n;
  logic         srise_n, sfall_n;

  sigchg_prev #(.W(W)) u_prev (
    .clk(clk), .rst_n(rst_n), .load_i(scan_i), .word_i(word_i),
    .prev_o(prev_w), .primed_o(primed_w)
  );

  sigchg_calc #(.W(W)) u_calc (
    .prev_i(prev_w), .word_i(word_i), .keep_i(keep_mask_i),
    .valid_i(primed_w),
    .chg_o(chg_n), .rise_o(rise_n), .fall_o(fall_n)
  );

  sigchg_pick #(.W(W), .SELW(SELW)) u_pick (
    .rise_i(rise_n), .fall_i(fall_n), .sel_i(sel_i),
    .rise_o(srise_n), .fall_o(sfall_n)
  );

  sigchg_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(scan_i),
    .chg_i(chg_n), .rise_i(rise_n), .fall_i(fall_n),
    .srise_i(srise_n), .sfall_i(sfall_n),
    .chg_o(chg_o), .rise_o(rise_o), .fall_o(fall_o),
    .srise_o(sel_rise_o), .sfall_o(sel_fall_o)
  );
endmodule

// File: rtl/sigchg_det_chk.sv
`timescale 1ns/1ps
module sigchg_det_chk #(
  parameter int W    = 16,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_i,
  input logic [W-1:0]    keep_mask_i,
  input logic [SELW-1:0] sel_i,
  input logic [W-1:0]    chg_o,
  input logic [W-1:0]    rise_o,
  input logic [W-1:0]    fall_o,
  input logic            sel_rise_o,
  input logic            sel_fall_o,
  input logic            primed_w
);
  // R2: the first strobe after reset reports nothing
  p_first_scan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_i && !primed_w) |=> (chg_o == '0 && !sel_rise_o && !sel_fall_o));

  // R4 and R5: the two directions split the changed mask
  p_dirs_cover_chg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o | fall_o) == chg_o);
  p_dirs_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & fall_o) == '0);

  // R6: outputs hold when no strobe was seen
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_i |=> ($stable(chg_o) && $stable(rise_o) && $stable(fall_o)
                 && $stable(sel_rise_o) && $stable(sel_fall_o)));

  // R7: positions dropped from the keep mask read 0
  p_masked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_i |=> ((chg_o & ~$past(keep_mask_i)) == '0));

  // R8: selected pulses follow the sampled select
  p_sel_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_i |=> (sel_rise_o == rise_o[$past(sel_i)]));
  p_sel_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_i |=> (sel_fall_o == fall_o[$past(sel_i)]));
endmodule

bind sigchg_det sigchg_det_chk #(.W(W), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_i(scan_i), .keep_mask_i(keep_mask_i),
  .sel_i(sel_i), .chg_o(chg_o), .rise_o(rise_o), .fall_o(fall_o),
  .sel_rise_o(sel_rise_o), .sel_fall_o(sel_fall_o), .primed_w(primed_w)
);

// File: tb/sigchg_det_test.sv
`timescale 1ns/1ps
module sigchg_det_test;
  localparam int W = 16;
  localparam int SELW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic [W-1:0] keep_mask_i = '1;
  logic [SELW-1:0] sel_i = '0;
  logic [W-1:0] chg_o, rise_o, fall_o;
  logic sel_rise_o, sel_fall_o;

  int tests = 0;
  int failed = 0;
  bit done = 0;

  logic [W-1:0] prev_m = '0;
  bit primed_m = 0;
  logic [W-1:0] e_chg = '0, e_rise = '0, e_fall = '0;
  logic e_sr = 0, e_sf = 0;

  always #2.5 clk = ~clk;

  sigchg_det #(.W(W), .SELW(SELW)) uut (
    .clk(clk), .rst_n(rst_n), .scan_i(scan_i), .word_i(word_i),
    .keep_mask_i(keep_mask_i), .sel_i(sel_i), .chg_o(chg_o),
    .rise_o(rise_o), .fall_o(fall_o), .sel_rise_o(sel_rise_o),
    .sel_fall_o(sel_fall_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " chg R3"},  32'(chg_o),  32'(e_chg));
    chk({tag, " rise R4"}, 32'(rise_o), 32'(e_rise));
    chk({tag, " fall R5"}, 32'(fall_o), 32'(e_fall));
    chk({tag, " srise R8"}, 32'(sel_rise_o), 32'(e_sr));
    chk({tag, " sfall R8"}, 32'(sel_fall_o), 32'(e_sf));
  endtask

  // One scan: strobe for one cycle, check one cycle later (R10), then hold (R6).
  task automatic scan(input logic [W-1:0] w, input logic [W-1:0] m,
                      input logic [SELW-1:0] s);
    @(negedge clk);
    word_i = w; keep_mask_i = m; sel_i = s; scan_i = 1'b1;
    for (int b = 0; b < W; b++) begin
      logic c;
      c = primed_m && m[b] && (prev_m[b] != w[b]);
      e_chg[b]  = c;
      e_rise[b] = c && w[b];
      e_fall[b] = c && !w[b];
    end
    e_sr = e_rise[s];
    e_sf = e_fall[s];
    prev_m = w;
    primed_m = 1;
    @(negedge clk);
    scan_i = 1'b0;
    check_all("R10 scan");
    word_i = ~w; keep_mask_i = ~m; sel_i = ~s;
    @(negedge clk);
    check_all("R6 hold");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset chg", 32'(chg_o), 0);
    chk("R1 reset rise", 32'(rise_o), 0);
    chk("R1 reset fall", 32'(fall_o), 0);
    chk("R1 reset pulses", {30'd0, sel_rise_o, sel_fall_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 released chg", 32'(chg_o), 0);

    // R2: first scan loads only
    scan(16'hFFFF, 16'hFFFF, 4'd3);
    chk("R2 first scan quiet", 32'(chg_o), 0);
    // stored word must be FFFF: all-zero word now falls everywhere
    scan(16'h0000, 16'hFFFF, 4'd5);
    chk("R2 prev loaded", 32'(fall_o), 32'h0000FFFF);

    // R9 worked example
    scan(16'h000A, 16'hFFFF, 4'd2);
    scan(16'h000C, 16'hFFFF, 4'd2);
    chk("R9 chg", 32'(chg_o), 32'h6);
    chk("R9 rise", 32'(rise_o), 32'h4);
    chk("R9 fall", 32'(fall_o), 32'h2);
    chk("R9 sel bit2 rise R8", 32'(sel_rise_o), 1);

    // R7: toggle bit0 while masked, then keep it with no further change
    scan(16'h0000, 16'hFFFF, 4'd0);
    scan(16'h0001, 16'hFFFE, 4'd0);
    chk("R7 masked toggle hidden", 32'(chg_o), 0);
    scan(16'h0001, 16'hFFFF, 4'd0);
    chk("R7 prev tracked unmasked", 32'(chg_o), 0);

    // R8: pulse lasts one scan only
    scan(16'h0101, 16'hFFFF, 4'd8);
    chk("R8 pulse on", 32'(sel_rise_o), 1);
    scan(16'h0101, 16'hFFFF, 4'd8);
    chk("R8 pulse gone next scan", 32'(sel_rise_o), 0);

    // Sweep: every old/new low-nibble pair, varied upper bits, masks, selects
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        logic [W-1:0] m;
        m = (((o + n) % 4) == 0) ? 16'hF0F5 : ((((o + n) % 4) == 1) ? 16'h3FFE : 16'hFFFF);
        scan({4'(o), 4'(n), 4'(o ^ n), 4'(o)}, m, 4'((o * 3 + n) % 16));
        scan({4'(n), 4'(o), 4'(o + n), 4'(n)}, m, 4'((o + n) % 16));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule